// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves byte-wide channels between serial time-division streams. Four serial inputs are each shifted into bytes, and every completed byte is stored in a two-bank data buffer. The buffer address comes from a bit counter that a frame pulse clears. Four serial outputs are rebuilt channel by channel. For each output channel, a connection table entry picks the source stream and the source channel. The entry can instead supply a fixed message byte, or turn that output channel off.

The frame carries 32, 64 or 128 channels per stream. Each switched output channel uses one of two delay policies. Variable delay takes the byte from the current frame whenever that byte is already stored, which gives the lowest latency. Constant delay always takes the byte from the frame before, so every connection sees the same frame delay. The connection table and a small control word are loaded through a write-only port. A global disable input and a standby control bit turn off all outputs at once.

Top module: `tdm_slot_switch`

## Requirements
- R1: The bit counter is cleared by the clock edge that samples `frame_pulse` high. In the cycle where the counter holds value c, input and output channel c/8 carry bit 7-(c mod 8), so bytes are sent most significant bit first.
- R2: Control bits [1:0] set the channels per stream: 0 gives 32, 1 gives 64, 2 or 3 gives 128. The frame is 8 bit cycles per channel long. Without a pulse, the counter wraps to 0 after its last bit.
- R3: Only the low 5, 6 or 7 bits of the entry's source channel field [7:0] are used at 32, 64 or 128 channels. Higher bits have no effect.
- R4: An entry with bit 12 clear uses variable delay. If output channel m is greater than source channel n plus 2, the output carries the byte of input channel n from the same frame.
- R5: With variable delay and m ≤ n+2, the output carries the byte of input channel n from the previous frame. This includes m = 0 with n equal to the last channel.
- R6: An entry with bit 12 set uses constant delay. The output always carries the byte of input channel n from the previous frame.
- R7: An entry with bit 13 set sends its bits [7:0] as the channel byte, in place of switched data.
- R8: An entry with bit 14 set holds `st_oe` low for that stream and channel only. Output enable changes only at channel boundaries, unless a global disable changes.
- R9: While `out_dis` is high, every `st_oe` bit is low.
- R10: While control bit 2 (standby) is set, every `st_oe` bit is low.
- R11: A write with address bit 9 clear stores `wr_data` as the entry at stream `wr_addr[8:7]`, channel `wr_addr[6:0]`. The entry's source stream is in bits [9:8]. A write with address bit 9 set loads the control word from `wr_data[2:0]`.
- R12: While reset is held, and in the cycle after it, all `st_oe` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| frame_pulse | input | 1 | Frame start marker, sampled high for one cycle before bit 0 |
| st_in | input | 4 | Serial input streams |
| st_out | output | 4 | Serial output streams |
| st_oe | output | 4 | Per-stream output driver enable |
| out_dis | input | 1 | Global output disable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 10 | Write address: bit 9 selects control, else {stream, channel} |
| wr_data | input | 16 | Connection entry or control word |

## Verification
The bench targets the read/write collision at the frame seam. There, output channel 0 is fed from the last input channel, which is stored on the very edge that loads the output. Without forwarding, the design would send a byte two frames stale. It also sets variable-delay links exactly at m = n+2 and m = n+3. Getting the comparison off by one would move those channels a whole frame in latency. Source channel fields carry stray upper bits at 32 and 64 channels, which an unmasked design would use to read the wrong slot. Global disable, standby and per-channel high impedance are mixed with rate changes, so that an enable that leaks or changes mid-channel shows up at once.

// File: rtl/tdm_slot_switch.sv
`timescale 1ns/1ps
module tdm_slot_switch #(
  parameter int NSTR   = 4,
  parameter int CH_MAX = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_pulse,
  input  logic [NSTR-1:0]  st_in,
  output logic [NSTR-1:0]  st_out,
  output logic [NSTR-1:0]  st_oe,
  input  logic             out_dis,
  input  logic             wr_en,
  input  logic [$clog2(NSTR)+$clog2(CH_MAX):0] wr_addr,
  input  logic [15:0]      wr_data
);
  localparam int SW  = $clog2(NSTR);
  localparam int CHW = $clog2(CH_MAX);
  localparam int BW  = CHW + 3;
  localparam int AW  = 1 + SW + CHW;
  localparam logic [CHW:0] TWO = 2;

  logic [1:0]      rate_q;
  logic            stby_q;
  logic [BW-1:0]   bitcnt, last_bit;
  logic [CHW-1:0]  ch_mask, cur_ch, nxt_ch;
  logic            wr_bank, frame_bank, boundary, load;

  logic [7:0]  dmem [2*NSTR*CH_MAX];
  logic [15:0] cmem [NSTR*CH_MAX];
  logic [6:0]  sh      [NSTR];
  logic [7:0]  byte_in [NSTR];

  always_comb begin
    case (rate_q)
      2'd0:    ch_mask = CHW'(CH_MAX/4 - 1);
      2'd1:    ch_mask = CHW'(CH_MAX/2 - 1);
      default: ch_mask = CHW'(CH_MAX - 1);
    endcase
  end

  assign last_bit   = {ch_mask, 3'b111};
  assign boundary   = frame_pulse || (bitcnt >= last_bit);
  assign load       = boundary || (bitcnt[2:0] == 3'd7);
  assign cur_ch     = bitcnt[BW-1:3];
  assign nxt_ch     = boundary ? '0 : cur_ch + 1'b1;
  assign frame_bank = boundary ? ~wr_bank : wr_bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt  <= '0;
      wr_bank <= 1'b0;
      rate_q  <= 2'd0;
      stby_q  <= 1'b0;
    end else begin
      bitcnt  <= boundary ? '0 : bitcnt + 1'b1;
      wr_bank <= wr_bank ^ boundary;
      if (wr_en && wr_addr[AW-1]) {stby_q, rate_q} <= wr_data[2:0];
    end
  end

  always_comb
    for (int s = 0; s < NSTR; s++) byte_in[s] = {sh[s], st_in[s]};

  always_ff @(posedge clk) begin
    for (int s = 0; s < NSTR; s++) sh[s] <= {sh[s][5:0], st_in[s]};
    if (bitcnt[2:0] == 3'd7)
      for (int s = 0; s < NSTR; s++) dmem[{wr_bank, SW'(s), cur_ch}] <= byte_in[s];
  end

  always_ff @(posedge clk)
    if (wr_en && !wr_addr[AW-1]) cmem[wr_addr[AW-2:0]] <= wr_data;

  for (genvar t = 0; t < NSTR; t++) begin : g_out
    logic [15:0]    ent;
    logic [SW-1:0]  src_s;
    logic [CHW-1:0] src_n;
    logic           use_prev, rd_bank, hit;
    logic [7:0]     sw_byte, osh;
    logic           oe_q;

    assign ent      = cmem[{SW'(t), nxt_ch}];
    assign src_s    = ent[8 +: SW];
    assign src_n    = ent[CHW-1:0] & ch_mask;
    assign use_prev = ent[12] || ({1'b0, nxt_ch} <= {1'b0, src_n} + TWO);
    assign rd_bank  = use_prev ? ~frame_bank : frame_bank;
    assign hit      = (bitcnt[2:0] == 3'd7) && (rd_bank == wr_bank) && (src_n == cur_ch);
    assign sw_byte  = hit ? byte_in[src_s] : dmem[{rd_bank, src_s, src_n}];

    always_ff @(posedge clk) begin
      if (rst) begin
        osh  <= '0;
        oe_q <= 1'b0;
      end else if (load) begin
        osh  <= ent[13] ? ent[7:0] : sw_byte;
        oe_q <= ~ent[14];
      end else begin
        osh  <= {osh[6:0], 1'b0};
      end
    end

    assign st_out[t] = osh[7];
    assign st_oe[t]  = oe_q & ~out_dis & ~stby_q;
  end
endmodule

// File: rtl/tdm_slot_switch_chk.sv
`timescale 1ns/1ps
module tdm_slot_switch_chk #(
  parameter int NSTR = 4,
  parameter int BW   = 10,
  parameter int AW   = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            frame_pulse,
  input logic            out_dis,
  input logic [NSTR-1:0] st_oe,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [15:0]     wr_data,
  input logic [BW-1:0]   bitcnt,
  input logic [BW-1:0]   last_bit,
  input logic            stby_q,
  input logic [1:0]      rate_q
);
  assert_oe_in_reset_R12: assert property (@(posedge clk) rst |=> st_oe == '0);

  assert_pulse_clears_R1: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |=> bitcnt == '0);

  assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (!frame_pulse && bitcnt >= last_bit) |=> bitcnt == '0);

  assert_global_off_R9: assert property (@(posedge clk) disable iff (rst)
    out_dis |-> st_oe == '0);

  assert_standby_off_R10: assert property (@(posedge clk) disable iff (rst)
    stby_q |-> st_oe == '0);

  assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[AW-1]) |=> {stby_q, rate_q} == $past(wr_data[2:0]));

  assert_oe_per_slot_R8: assert property (@(posedge clk) disable iff (rst)
    (!frame_pulse && bitcnt[2:0] != 3'd7) |=>
      ($stable(st_oe) || !$stable(out_dis) || !$stable(stby_q)));
endmodule

bind tdm_slot_switch tdm_slot_switch_chk #(.NSTR(NSTR), .BW(BW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .frame_pulse(frame_pulse), .out_dis(out_dis), .st_oe(st_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .bitcnt(bitcnt),
  .last_bit(last_bit), .stby_q(stby_q), .rate_q(rate_q)
);

// File: tb/tdm_slot_switch_test.sv
`timescale 1ns/1ps
module tdm_slot_switch_test;
  logic clk = 0, rst = 1, fp = 0, out_dis = 0, wr_en = 0;
  logic [3:0]  st_in = '0;
  logic [3:0]  st_out, st_oe;
  logic [9:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;

  always #2.5 clk = ~clk;

  tdm_slot_switch uut (
    .clk(clk), .rst(rst), .frame_pulse(fp), .st_in(st_in), .st_out(st_out),
    .st_oe(st_oe), .out_dis(out_dis), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  typedef struct { int fr; int ch; int st; logic [7:0] b; bit oe; string tag; } exp_t;
  exp_t q[$];
  int errors = 0, checks = 0;
  int wq_n = 0;
  logic [9:0]  wq_a [600];
  logic [15:0] wq_d [600];
  logic [15:0] cfgm [4][128];

  function automatic logic [7:0] pat(int f, int s, int n);
    return 8'((f*29 + s*67 + n*11 + 3) % 256);
  endfunction

  function automatic logic [15:0] mk_entry(int t, int m, int nch);
    logic [6:0] hi;
    int s, n;
    bit cd;
    hi = 7'(~(nch-1));
    s = (t + 1 + m) % 4;
    cd = 0;
    n = 0;
    if (m == 0) n = nch - 1;                       // seam: last channel into channel 0
    else case (m % 8)
      0: n = m - 3;
      1: n = m - 2;
      2: begin n = (m + nch - 3) % nch; cd = 1; end
      3: return {3'b001, 5'd0, 8'(8'h5A ^ m)};
      4: return {2'b01, 14'd0};
      5: n = (m + 5) % nch;
      6: n = m / 2;
      default: begin n = m; cd = 1; end
    endcase
    return {3'b000, cd, 2'b00, 2'(s), 1'b1, 7'(n) | hi};
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic build_cfg(int rate, int nch, bit sby, bit with_cm);
    wq_a[0] = 10'h200;
    wq_d[0] = {13'd0, sby, 2'(rate)};
    wq_n = 1;
    if (with_cm)
      for (int m = 0; m < nch; m++)
        for (int t = 0; t < 4; t++) begin
          cfgm[t][m] = mk_entry(t, m, nch);
          wq_a[wq_n] = {1'b0, 2'(t), 7'(m)};
          wq_d[wq_n] = cfgm[t][m];
          wq_n++;
        end
  endtask

  // driver: pushes expected channel bytes, then plays one frame
  task automatic drive_frame(int f, int nch, bit check, bit dis, bit sby, bit do_wr, string xtag);
    if (check)
      for (int m = 0; m < nch; m++)
        for (int t = 0; t < 4; t++) begin
          exp_t r;
          logic [15:0] e;
          int n;
          bit prev;
          e = cfgm[t][m];
          r.fr = f; r.ch = m; r.st = t;
          r.oe = !e[14] && !dis && !sby;
          if (e[13]) begin
            r.b = e[7:0];
            r.tag = "R7 R11";
          end else begin
            n = int'(e[6:0] & 7'(nch-1));
            prev = e[12] || (m <= n + 2);
            r.b = pat(prev ? f-1 : f, int'(e[9:8]), n);
            if (e[14]) r.tag = "R8";
            else if (e[12]) r.tag = "R6";
            else if (prev) r.tag = "R5";
            else r.tag = "R4";
          end
          r.tag = {r.tag, " R1 ", xtag, dis ? " R9" : "", sby ? " R10" : ""};
          q.push_back(r);
        end
    for (int c = 0; c < nch*8; c++) begin
      @(negedge clk); #1;
      for (int s = 0; s < 4; s++) begin
        logic [7:0] b;
        b = pat(f, s, c/8);
        st_in[s] = b[7 - c%8];
      end
      fp = (c == nch*8 - 1);
      out_dis = dis;
      if (do_wr && c < wq_n) begin
        wr_en = 1; wr_addr = wq_a[c]; wr_data = wq_d[c];
      end else wr_en = 0;
    end
  endtask

  // monitor
  int mc = 0, mfr = 0;
  logic [7:0] msh [4];
  always @(posedge clk) begin
    if (fp) begin mc <= 0; mfr <= mfr + 1; end
    else mc <= mc + 1;
  end

  always @(negedge clk) begin
    for (int t = 0; t < 4; t++) msh[t] = {msh[t][6:0], st_out[t]};
    if (!rst && mc % 8 == 7)
      while (q.size() > 0 && q[0].fr == mfr && q[0].ch == mc/8) begin
        exp_t r;
        r = q.pop_front();
        chk(st_oe[r.st] == r.oe, {r.tag, " enable"}, int'(st_oe[r.st]), int'(r.oe));
        if (r.oe) chk(msh[r.st] == r.b, {r.tag, " byte"}, int'(msh[r.st]), int'(r.b));
      end
  end

  initial begin
    #(100000 * 5);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(st_oe == 4'b0, "R12 in reset", int'(st_oe), 0);
    #1 rst = 0;
    @(negedge clk);
    chk(st_oe == 4'b0, "R12 after reset", int'(st_oe), 0);
    #1 fp = 1;
    build_cfg(0, 32, 0, 1);
    drive_frame(1, 32, 0, 0, 0, 1, "");
    drive_frame(2, 32, 1, 0, 0, 0, "R3");
    drive_frame(3, 32, 1, 1, 0, 0, "R3");
    drive_frame(4, 32, 1, 0, 0, 0, "R3");
    build_cfg(0, 32, 1, 0);
    drive_frame(5, 32, 0, 0, 0, 1, "");
    drive_frame(6, 32, 1, 0, 1, 0, "R11");
    build_cfg(1, 64, 0, 1);
    drive_frame(7, 64, 0, 0, 0, 1, "");
    drive_frame(8, 64, 1, 0, 0, 0, "R2 R3");
    build_cfg(2, 128, 0, 1);
    drive_frame(9, 128, 0, 0, 0, 1, "");
    drive_frame(10, 128, 1, 0, 0, 0, "R2");
    build_cfg(0, 32, 0, 1);
    drive_frame(11, 32, 0, 0, 0, 1, "");
    drive_frame(12, 32, 1, 0, 0, 0, "R2 R3");
    @(negedge clk); #1 fp = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    while (q.size() > 0) begin
      exp_t r;
      r = q.pop_front();
      chk(0, {r.tag, " never seen"}, r.ch, r.st);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule